// File: doc/BRIEF.md
# Criticality-Steered Split Level-One Data Cache

This block is a level-one data cache built from two separate two-way set-associative banks that share one request port. The small bank answers quickly and is meant for loads that the core marks as critical. The larger bank answers in exactly twice the time and holds data for non-critical loads. A policy input chooses which banks each request looks in. The block returns the word with the latency of the bank that served it. A load that misses every bank it looked in fetches the whole 32-byte line from the next level. The line is then placed in the bank that matches the load's criticality.

Only one miss can be in flight at a time. While it is pending, `req_ready` stays low. Stores write through to the next level in the cycle they are accepted. A store never allocates a line. Every response is tagged with its source: the fast bank, the slow bank or the next level. This tag shows where each load was routed.

Top module: `split_dc_top`

## Requirements
- R1: With `policy`=0, a critical load looks only in the fast bank and a non-critical load looks only in the slow bank. A line held only in the bank that was not probed counts as a miss.
- R2: With `policy`=1, a critical load looks in both banks. A non-critical load looks only in the slow bank.
- R3: With `policy`=2 or 3, every load looks in both banks. A line in the fast bank is then served from the fast bank.
- R4: A load served by the fast bank raises `rsp_valid` exactly FAST_LAT cycles after the accepting edge. It returns `rsp_src`=1 and the addressed 32-bit word.
- R5: A load served by the slow bank raises `rsp_valid` exactly 2×FAST_LAT cycles after the accepting edge, with `rsp_src`=2.
- R6: On a load miss, `nl_req_valid` rises with `nl_req_addr` equal to the address bits above the 5-bit line offset. It stays stable until `nl_rsp_valid` arrives. The response follows one cycle after that, with `rsp_src`=3. The line goes into the fast bank for a critical load and into the slow bank otherwise.
- R7: Filling a line into one bank removes any copy of that line from the other bank. No line is ever held in both banks.
- R8: Each bank keeps one recency bit per set. A fill uses an empty way first. If the set is full, the fill replaces the way used less recently.
- R9: `req_ready` is low from the edge that accepts a missing load until that load's response.
- R10: A store asserts `nl_wr_valid` with the same address and data while it is presented and `req_ready` is high. It updates any bank copy of the word, whatever the policy. It never allocates a line and produces no response.
- R11: After reset both banks are empty, `req_ready` is high, and `rsp_valid` and `nl_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Probe policy, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_crit | input | 1 | Criticality tag of the request |
| req_addr | input | ADDR_W | Byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 32 | Load data |
| rsp_src | output | 2 | 1 fast bank, 2 slow bank, 3 next level, 0 idle |
| nl_req_valid | output | 1 | Line fetch request to next level |
| nl_req_addr | output | ADDR_W-5 | Line address of the fetch |
| nl_rsp_valid | input | 1 | Fetched line present |
| nl_rsp_line | input | 256 | Fetched line, word 0 in the low bits |
| nl_wr_valid | output | 1 | Write-through strobe |
| nl_wr_addr | output | ADDR_W | Write-through byte address |
| nl_wr_data | output | 32 | Write-through data |

## Verification
The bench uses the default values: 16-bit addresses, a 32-line baseline and FAST_LAT=1. With these, the fast bank has 4 sets and the slow bank has 8 sets. Addresses 128 bytes apart therefore collide in one fast set, which makes it easy to fill a set and force an eviction with three lines. The one-cycle and two-cycle hit latencies can be counted exactly. Small address steps are enough to move a line between the banks and confirm that the copy in the other bank is removed.

// File: rtl/split_dc_pkg.sv
package split_dc_pkg;
  localparam int OFS_W  = 5;
  localparam int WORD_W = 32;
  localparam int WORDS  = 8;
  localparam int LINE_W = WORD_W * WORDS;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FAST = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_NEXT = 2'd3
  } src_e;

  // does this request look in the fast bank
  function automatic logic probe_fast(input logic [1:0] pol, input logic crit);
    return crit || pol[1];
  endfunction

  // does this request look in the slow bank
  function automatic logic probe_slow(input logic [1:0] pol, input logic crit);
    return !crit || (pol != 2'd0);
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [2:0] idx);
    return line[idx*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/split_dc_bank.sv
module split_dc_bank
  import split_dc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_line,
  input  logic              touch_en,
  input  logic              upd_en,
  input  logic [WORD_W-1:0] upd_data,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              inv_en
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFS_W - SET_W;

  logic [1:0]        valid_q [SETS];
  logic [SETS-1:0]   lru_q;
  logic [TAG_W-1:0]  tag_q   [SETS][2];
  logic [LINE_W-1:0] data_q  [SETS][2];

  logic [SET_W-1:0] set_i;
  logic [TAG_W-1:0] tag_i;
  logic [2:0]       widx;
  logic [1:0]       way_hit;
  logic             hit_way;
  logic             victim;

  assign set_i = lk_addr[OFS_W +: SET_W];
  assign tag_i = lk_addr[ADDR_W-1 -: TAG_W];
  assign widx  = lk_addr[OFS_W-1:2];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_hit[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  assign lk_hit  = |way_hit;
  assign hit_way = way_hit[1];
  assign lk_line = data_q[set_i][hit_way];
  assign victim  = !valid_q[set_i][0] ? 1'b0 :
                   !valid_q[set_i][1] ? 1'b1 : lru_q[set_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= 2'b00;
      lru_q <= '0;
    end else begin
      if (inv_en) valid_q[set_i] <= valid_q[set_i] & ~way_hit;
      if (fill_en) begin
        valid_q[set_i][victim] <= 1'b1;
        lru_q[set_i]           <= ~victim;
      end
      if (touch_en) lru_q[set_i] <= ~hit_way;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_q[set_i][victim] <= fill_line;
      tag_q[set_i][victim]  <= tag_i;
    end
    if (upd_en && lk_hit) data_q[set_i][hit_way][widx*WORD_W +: WORD_W] <= upd_data;
  end

  AST_FILL_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !lk_hit); // R6
  AST_ONE_WAY_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    way_hit != 2'b11); // R8
  AST_TOUCH_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |-> lk_hit); // R8
endmodule

// File: rtl/split_dc_top.sv
module split_dc_top
  import split_dc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BASE_LINES = 32,
  parameter int FAST_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        policy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_crit,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [1:0]        rsp_src,
  output logic              nl_req_valid,
  output logic [ADDR_W-6:0] nl_req_addr,
  input  logic              nl_rsp_valid,
  input  logic [255:0]      nl_rsp_line,
  output logic              nl_wr_valid,
  output logic [ADDR_W-1:0] nl_wr_addr,
  output logic [31:0]       nl_wr_data
);
  localparam int FAST_SETS = BASE_LINES / 8;
  localparam int SLOW_SETS = BASE_LINES / 4;
  localparam int SLOW_LAT  = 2 * FAST_LAT;
  localparam int CNT_W     = $clog2(SLOW_LAT + 2) + 1;

  typedef enum logic [1:0] {S_IDLE, S_HIT, S_MISS, S_RESP} st_e;

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_crit_q;
  logic [1:0]        src_q;
  logic [31:0]       data_q;

  logic [ADDR_W-1:0] lk_addr;
  logic [LINE_W-1:0] f_line, s_line;
  logic f_hit, s_hit, pf, ps;
  logic accept, acc_ld, acc_st, f_serve, s_serve, fill_done;
  logic f_touch, s_touch, f_fill, s_fill;

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign acc_ld    = accept && !req_write;
  assign acc_st    = accept && req_write;
  assign lk_addr   = req_ready ? req_addr : pend_addr_q;
  assign pf        = probe_fast(policy, req_crit);
  assign ps        = probe_slow(policy, req_crit);
  assign f_serve   = pf && f_hit;
  assign s_serve   = ps && s_hit && !f_serve;
  assign fill_done = (st_q == S_MISS) && nl_rsp_valid;
  assign f_touch   = accept && f_serve;
  assign s_touch   = accept && s_serve;
  assign f_fill    = fill_done && pend_crit_q;
  assign s_fill    = fill_done && !pend_crit_q;

  split_dc_bank #(.ADDR_W(ADDR_W), .SETS(FAST_SETS)) u_fast (
    .clk, .rst_n, .lk_addr, .lk_hit(f_hit), .lk_line(f_line),
    .touch_en(f_touch), .upd_en(acc_st), .upd_data(req_wdata),
    .fill_en(f_fill), .fill_line(nl_rsp_line), .inv_en(s_fill));

  split_dc_bank #(.ADDR_W(ADDR_W), .SETS(SLOW_SETS)) u_slow (
    .clk, .rst_n, .lk_addr, .lk_hit(s_hit), .lk_line(s_line),
    .touch_en(s_touch), .upd_en(acc_st), .upd_data(req_wdata),
    .fill_en(s_fill), .fill_line(nl_rsp_line), .inv_en(f_fill));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      pend_addr_q <= '0;
      pend_crit_q <= 1'b0;
      src_q       <= SRC_NONE;
      data_q      <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (acc_ld) begin
          pend_addr_q <= req_addr;
          pend_crit_q <= req_crit;
          if (f_serve) begin
            st_q   <= S_HIT;
            cnt_q  <= CNT_W'(FAST_LAT - 1);
            src_q  <= SRC_FAST;
            data_q <= pick_word(f_line, req_addr[4:2]);
          end else if (s_serve) begin
            st_q   <= S_HIT;
            cnt_q  <= CNT_W'(SLOW_LAT - 1);
            src_q  <= SRC_SLOW;
            data_q <= pick_word(s_line, req_addr[4:2]);
          end else begin
            st_q <= S_MISS;
          end
        end
        S_HIT: if (cnt_q == '0) st_q <= S_IDLE;
               else cnt_q <= cnt_q - 1'b1;
        S_MISS: if (nl_rsp_valid) begin
          st_q   <= S_RESP;
          src_q  <= SRC_NEXT;
          data_q <= pick_word(nl_rsp_line, pend_addr_q[4:2]);
        end
        S_RESP: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid    = ((st_q == S_HIT) && (cnt_q == '0)) || (st_q == S_RESP);
  assign rsp_data     = data_q;
  assign rsp_src      = rsp_valid ? src_q : SRC_NONE;
  assign nl_req_valid = (st_q == S_MISS);
  assign nl_req_addr  = pend_addr_q[ADDR_W-1:OFS_W];
  assign nl_wr_valid  = acc_st;
  assign nl_wr_addr   = req_addr;
  assign nl_wr_data   = req_wdata;

  // cycles since the last accepted request, for latency properties
  logic [CNT_W-1:0] since_acc;
  always_ff @(posedge clk) begin
    if (!rst_n) since_acc <= '1;
    else if (accept) since_acc <= CNT_W'(1);
    else if (since_acc != '1) since_acc <= since_acc + 1'b1;
  end

  AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src == SRC_FAST) |-> since_acc == CNT_W'(FAST_LAT)); // R4
  AST_SLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src == SRC_SLOW) |-> since_acc == CNT_W'(SLOW_LAT)); // R5
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid && !nl_rsp_valid) |=> nl_req_valid && $stable(nl_req_addr)); // R6
  AST_FILL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> rsp_valid && rsp_src == SRC_NEXT); // R6
  AST_BANKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_hit && s_hit)); // R7
  AST_BUSY_DURING_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req_valid |-> !req_ready); // R9
  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_st && req_ready) |=> !rsp_valid); // R10
endmodule

// File: tb/split_dc_top_test.sv
module split_dc_top_test;
  localparam logic [1:0] FAST = 2'd1, SLOW = 2'd2, NEXT = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] policy = 2'd0;
  logic req_valid = 1'b0, req_write = 1'b0, req_crit = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, nl_req_valid, nl_wr_valid;
  logic [31:0] rsp_data, nl_wr_data;
  logic [1:0] rsp_src;
  logic [10:0] nl_req_addr;
  logic nl_rsp_valid = 1'b0;
  logic [255:0] nl_rsp_line = '0;
  logic [15:0] nl_wr_addr;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] mem [16384];

  always #5 clk = ~clk;

  split_dc_top uut (
    .clk, .rst_n, .policy, .req_valid, .req_ready, .req_write, .req_crit,
    .req_addr, .req_wdata, .rsp_valid, .rsp_data, .rsp_src, .nl_req_valid,
    .nl_req_addr, .nl_rsp_valid, .nl_rsp_line, .nl_wr_valid, .nl_wr_addr, .nl_wr_data);

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // next-level memory model: answers a fetch three cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (nl_req_valid) begin
        logic [10:0] la;
        la = nl_req_addr;
        repeat (3) @(negedge clk);
        for (int w = 0; w < 8; w++) nl_rsp_line[w*32 +: 32] = mem[{la, w[2:0]}];
        nl_rsp_valid = 1'b1;
        @(negedge clk);
        nl_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_load(input logic [15:0] a, input logic c, input logic [1:0] pol,
                         input logic [1:0] es, input string rq);
    int lat;
    @(negedge clk);
    policy = pol; req_valid = 1'b1; req_write = 1'b0; req_crit = c; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (es == NEXT) begin
      check(!req_ready, "R9", "ready during miss", 64'(req_ready), 64'd0);
      check(nl_req_valid && nl_req_addr == a[15:5], "R6", "fetch address",
            64'(nl_req_addr), 64'(a[15:5]));
    end
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(rsp_src == es, rq, "response source", 64'(rsp_src), 64'(es));
    check(rsp_data == mem[a[15:2]], rq, "load data", 64'(rsp_data), 64'(mem[a[15:2]]));
    if (es == FAST) check(lat == 1, "R4", "fast latency", 64'(lat), 64'd1);
    if (es == SLOW) check(lat == 2, "R5", "slow latency", 64'(lat), 64'd2);
    if (es == NEXT) check(lat > 2, "R6", "miss latency above slow", 64'(lat), 64'd3);
  endtask

  task automatic do_store(input logic [15:0] a, input logic c, input logic [1:0] pol,
                          input logic [31:0] d);
    @(negedge clk);
    policy = pol; req_valid = 1'b1; req_write = 1'b1; req_crit = c;
    req_addr = a; req_wdata = d;
    #1;
    check(req_ready && nl_wr_valid && nl_wr_addr == a && nl_wr_data == d, "R10",
          "write-through", {nl_wr_addr, nl_wr_data}, {a, d});
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    mem[a[15:2]] = d;
    check(!rsp_valid && req_ready, "R10", "store gives no response", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset();
    check(req_ready, "R11", "ready after reset", 64'(req_ready), 64'd1);
    check(!rsp_valid, "R11", "no response after reset", 64'(rsp_valid), 64'd0);
    check(!nl_req_valid, "R11", "no fetch after reset", 64'(nl_req_valid), 64'd0);
  endtask

  task automatic t_split_routing();
    do_load(16'h0000, 1, 2'd0, NEXT, "R11");   // empty banks: first load misses
    do_load(16'h0004, 1, 2'd0, FAST, "R4");
    do_load(16'h1000, 0, 2'd0, NEXT, "R6");
    do_load(16'h1008, 0, 2'd0, SLOW, "R5");
    do_load(16'h0000, 0, 2'd0, NEXT, "R1");    // fast copy not probed
    do_load(16'h0000, 1, 2'd0, NEXT, "R7");    // fast copy was removed
    do_load(16'h0000, 0, 2'd0, NEXT, "R7");    // slow copy was removed
  endtask

  task automatic t_crit_both();
    do_load(16'h0000, 1, 2'd1, SLOW, "R2");
    do_load(16'h0020, 1, 2'd0, NEXT, "R1");
    do_load(16'h0020, 0, 2'd1, NEXT, "R2");
  endtask

  task automatic t_all_both();
    do_load(16'h0300, 1, 2'd0, NEXT, "R1");
    do_load(16'h0304, 0, 2'd2, FAST, "R3");
    do_load(16'h0308, 0, 2'd3, FAST, "R3");
    do_load(16'h1010, 1, 2'd2, SLOW, "R3");
  endtask

  task automatic t_lru();
    do_load(16'h0820, 1, 2'd0, NEXT, "R8");
    do_load(16'h08A0, 1, 2'd0, NEXT, "R8");
    do_load(16'h0824, 1, 2'd0, FAST, "R8");
    do_load(16'h0920, 1, 2'd0, NEXT, "R8");
    do_load(16'h0828, 1, 2'd0, FAST, "R8");
    do_load(16'h08A0, 1, 2'd0, NEXT, "R8");
  endtask

  task automatic t_stores();
    do_store(16'h0300, 1, 2'd0, 32'hDEADBEEF);
    do_load(16'h0300, 1, 2'd0, FAST, "R10");
    do_store(16'h0304, 0, 2'd0, 32'h12345678);
    do_load(16'h0304, 1, 2'd0, FAST, "R10");
    do_store(16'h2004, 0, 2'd0, 32'hCAFEF00D);
    do_load(16'h2004, 0, 2'd0, NEXT, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = 32'h5A000000 ^ (i * 32'h00010101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split_routing();
    t_crit_both();
    t_all_both();
    t_lru();
    t_stores();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule